// File: doc/BRIEF.md
# CIC Passband Droop Compensator (fixed stage count)

This block is a five-tap, linear-phase FIR correction filter placed after a CIC decimator. It flattens the passband droop of a CIC built with a fixed number of stages. That stage count is the parameter `STAGES` and lies between 1 and 6. Each stage count has its own coefficient set. The coefficients are integers scaled by 256, so the filter's DC gain is exactly 256. Every coefficient is built from shifts, additions and subtractions. Some of them reuse the small terms 3, 5, 7 and 9, and the block contains no multipliers.

Samples are signed and arrive with a strobe, at most one per clock. Cycles without the strobe leave the filter history untouched. The two symmetric tap pairs are added together before weighting, so only three coefficient networks exist. The output is registered and keeps full precision, with no rounding or saturation. A stage count outside 1..6 stops elaboration.

Top module: `cic_droop_comp`

## Requirements
- R1: `valid_out` is high in a cycle exactly when `valid_in` was high two cycles earlier, and low otherwise.
- R2: For the accepted samples x[k] (newest) back to x[k-4], the result is g0·x[k] + g1·x[k-1] + g2·x[k-2] + g1·x[k-3] + g0·x[k-4]. After reset, history that has not been filled counts as zero.
- R3: The (g0, g1, g2) set depends on `STAGES`: 1 → (2, −18, 288); 2 → (5, −40, 326); 3 → (9, −65, 368); 4 → (14, −94, 416); 5 → (21, −129, 472); 6 → (29, −168, 534).
- R4: A constant input c, accepted for five or more samples in a row, gives a result of exactly 256·c for every stage count.
- R5: A cycle with `valid_in` low does not change the filter history. `result_out` keeps its last value until the next `valid_out` cycle.
- R6: The result is exact over the full input range. It is signed and IN_W+11 bits wide, and its magnitude never exceeds (2|g0|+2|g1|+|g2|)·2^(IN_W−1).
- R7: Synchronous active-high `rst` clears the history, drives `valid_out` low and drives `result_out` to zero on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Sample strobe |
| sample_in | input | IN_W | Signed input sample |
| valid_out | output | 1 | Result strobe, two cycles after `valid_in` |
| result_out | output | OUT_W | Signed, full-precision filtered value with gain 256 |

## Verification
Suppose a history register is stuck or shifts on an idle cycle. Then the impulse response at `result_out` shows a wrong coefficient or a sample in the wrong position. This appears on the first or second strobed output after the fault and stays visible until five more samples have been accepted. A fault in one coefficient network changes the output for only one stage count. For that reason, six instances, one per stage count, are driven in parallel and compared against a bench model. Strobe latency errors appear as a mismatch on `valid_out` in the very next sampled cycle.

// File: rtl/cmpdroop_pkg.sv
package cmpdroop_pkg;

    // Width of the internal arithmetic; wide enough for any legal input width
    localparam int CALC_W   = 32;
    // Filter order is fixed: five taps, symmetric
    localparam int NUM_TAPS = 5;
    // Headroom bits needed above the input width (sum of |g| stays below 1024)
    localparam int GROWTH_W = 11;

    typedef logic signed [CALC_W-1:0] calc_t;

    // Symmetric taps folded into three operands
    typedef struct packed {
        calc_t outer;   // newest + oldest
        calc_t inner;   // second + fourth
        calc_t centre;  // middle tap
    } fold_t;

    // Weighted operands from the coefficient networks
    typedef struct packed {
        calc_t outer;
        calc_t inner;
        calc_t centre;
    } prod_t;

    // Shared shift-add terms
    function automatic calc_t by3(calc_t v);
        return (v <<< 2) - v;
    endfunction

    function automatic calc_t by5(calc_t v);
        return (v <<< 2) + v;
    endfunction

    function automatic calc_t by7(calc_t v);
        return (v <<< 3) - v;
    endfunction

    function automatic calc_t by9(calc_t v);
        return (v <<< 3) + v;
    endfunction

    function automatic bit stages_legal(int stages);
        return (stages >= 1) && (stages <= 6);
    endfunction

    function automatic int min_out_width(int in_w);
        return in_w + GROWTH_W;
    endfunction

    // Integer value of coefficient group (0 = outer, 1 = inner, 2 = centre)
    function automatic int coef_value(int stages, int grp);
        int tbl [3];
        case (stages)
            1:       tbl = '{2, -18, 288};
            2:       tbl = '{5, -40, 326};
            3:       tbl = '{9, -65, 368};
            4:       tbl = '{14, -94, 416};
            5:       tbl = '{21, -129, 472};
            default: tbl = '{29, -168, 534};
        endcase
        return tbl[grp];
    endfunction

    function automatic int abs_int(int v);
        return (v < 0) ? -v : v;
    endfunction

    // Sum of coefficient magnitudes over all five taps
    function automatic int coef_abs_sum(int stages);
        return 2 * abs_int(coef_value(stages, 0))
             + 2 * abs_int(coef_value(stages, 1))
             + abs_int(coef_value(stages, 2));
    endfunction

endpackage

// File: rtl/droop_tap_line.sv
module droop_tap_line
    import cmpdroop_pkg::*;
#(
    parameter int IN_W = 8,
    parameter int TAPS = NUM_TAPS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   shift_en,
    input  logic [IN_W-1:0]        din,
    output logic [TAPS*IN_W-1:0]   taps_flat
);

    // Slot 0 holds the newest sample, slot TAPS-1 the oldest
    logic [IN_W-1:0] slot [TAPS];

    always_ff @(posedge clk) begin
        if (rst) begin
            slot[0] <= '0;
        end else if (shift_en) begin
            slot[0] <= din;
        end
    end

    for (genvar i = 1; i < TAPS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot[i] <= '0;
            end else if (shift_en) begin
                slot[i] <= slot[i-1];
            end
        end
    end

    for (genvar i = 0; i < TAPS; i++) begin : g_flat
        assign taps_flat[i*IN_W +: IN_W] = slot[i];
    end

endmodule

// File: rtl/droop_fold.sv
module droop_fold
    import cmpdroop_pkg::*;
#(
    parameter int IN_W = 8
) (
    input  logic [NUM_TAPS*IN_W-1:0] taps_flat,
    output fold_t                    folded
);

    calc_t ext [NUM_TAPS];

    // Sign-extend every tap to the arithmetic width
    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_ext
        assign ext[i] = calc_t'($signed(taps_flat[i*IN_W +: IN_W]));
    end

    // Symmetry: equal coefficients share one pre-add
    always_comb begin
        folded.outer  = ext[0] + ext[NUM_TAPS-1];
        folded.inner  = ext[1] + ext[NUM_TAPS-2];
        folded.centre = ext[NUM_TAPS/2];
    end

endmodule

// File: rtl/droop_coef_net.sv
module droop_coef_net
    import cmpdroop_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  fold_t folded,
    output prod_t weighted
);

    calc_t so, si, sc;

    assign so = folded.outer;
    assign si = folded.inner;
    assign sc = folded.centre;

    // One hard-wired shift-add network per stage count
    if (STAGES == 1) begin : g_n1
        always_comb begin
            weighted.outer  = so <<< 1;                               // 2
            weighted.inner  = -(by9(si) <<< 1);                       // -18
            weighted.centre = by9(sc) <<< 5;                          // 288
        end
    end else if (STAGES == 2) begin : g_n2
        always_comb begin
            weighted.outer  = by5(so);                                // 5
            weighted.inner  = -(by5(si) <<< 3);                       // -40
            weighted.centre = (by5(sc) <<< 6) + (by3(sc) <<< 1);      // 326
        end
    end else if (STAGES == 3) begin : g_n3
        always_comb begin
            weighted.outer  = by9(so);                                // 9
            weighted.inner  = -((si <<< 6) + si);                     // -65
            weighted.centre = (sc <<< 9) - (by9(sc) <<< 4);           // 368
        end
    end else if (STAGES == 4) begin : g_n4
        always_comb begin
            weighted.outer  = by7(so) <<< 1;                          // 14
            weighted.inner  = -((by3(si) <<< 5) - (si <<< 1));        // -94
            weighted.centre = (by3(sc) <<< 7) + (sc <<< 5);           // 416
        end
    end else if (STAGES == 5) begin : g_n5
        always_comb begin
            weighted.outer  = (so <<< 4) + by5(so);                   // 21
            weighted.inner  = -((si <<< 7) + si);                     // -129
            weighted.centre = (sc <<< 9) - (by5(sc) <<< 3);           // 472
        end
    end else begin : g_n6
        always_comb begin
            weighted.outer  = (so <<< 5) - by3(so);                   // 29
            weighted.inner  = -((si <<< 7) + (by5(si) <<< 3));        // -168
            weighted.centre = (sc <<< 9) + (sc <<< 5) - (by5(sc) <<< 1); // 534
        end
    end

endmodule

// File: rtl/cic_droop_comp.sv
module cic_droop_comp
    import cmpdroop_pkg::*;
#(
    parameter int STAGES = 4,
    parameter int IN_W   = 8,
    parameter int OUT_W  = IN_W + GROWTH_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    valid_in,
    input  logic signed [IN_W-1:0]  sample_in,
    output logic                    valid_out,
    output logic signed [OUT_W-1:0] result_out
);

    localparam int FLAT_W = NUM_TAPS * IN_W;

    // Elaboration-time parameter checks
    if (!stages_legal(STAGES)) begin : g_bad_stages
        $error("cic_droop_comp: STAGES must lie between 1 and 6");
    end
    if (OUT_W < min_out_width(IN_W) || min_out_width(IN_W) > CALC_W) begin : g_bad_width
        $error("cic_droop_comp: output width too small or input too wide");
    end

    logic [FLAT_W-1:0] taps_flat;
    fold_t             folded;
    prod_t             weighted;
    calc_t             total;
    logic              stage1_vld;

    droop_tap_line #(
        .IN_W (IN_W),
        .TAPS (NUM_TAPS)
    ) tap_line_i (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (valid_in),
        .din       (sample_in),
        .taps_flat (taps_flat)
    );

    droop_fold #(
        .IN_W (IN_W)
    ) fold_i (
        .taps_flat (taps_flat),
        .folded    (folded)
    );

    droop_coef_net #(
        .STAGES (STAGES)
    ) coef_i (
        .folded   (folded),
        .weighted (weighted)
    );

    assign total = weighted.outer + weighted.inner + weighted.centre;

    // Strobe pipeline tracks the tap register and the output register
    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_vld <= 1'b0;
            valid_out  <= 1'b0;
        end else begin
            stage1_vld <= valid_in;
            valid_out  <= stage1_vld;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_out <= '0;
        end else if (stage1_vld) begin
            result_out <= OUT_W'(total);
        end
    end

endmodule

// File: rtl/droop_comp_chk.sv
module droop_comp_chk
    import cmpdroop_pkg::*;
#(
    parameter int STAGES = 4,
    parameter int IN_W   = 8,
    parameter int OUT_W  = IN_W + GROWTH_W
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    valid_in,
    input logic signed [IN_W-1:0]  sample_in,
    input logic                    valid_out,
    input logic signed [OUT_W-1:0] result_out
);

    localparam longint LIMIT = longint'(coef_abs_sum(STAGES)) <<< (IN_W - 1);

    // Sample value is unconstrained; referenced for completeness of the bind
    logic unused_ok;
    assign unused_ok = ^sample_in;

    // R1
    latency_hi_chk: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> ##1 valid_out);

    // R1
    latency_lo_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> ##1 !valid_out);

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid_out && !$past(rst)) |-> $stable(result_out));

    // R6
    range_chk: assert property (@(posedge clk) disable iff (rst)
        valid_out |-> (longint'(result_out) <= LIMIT && longint'(result_out) >= -LIMIT));

    // R7
    reset_chk: assert property (@(posedge clk)
        rst |=> (!valid_out && result_out == '0));

endmodule

bind cic_droop_comp droop_comp_chk #(
    .STAGES (STAGES),
    .IN_W   (IN_W),
    .OUT_W  (OUT_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .valid_in   (valid_in),
    .sample_in  (sample_in),
    .valid_out  (valid_out),
    .result_out (result_out)
);

// File: tb/cic_droop_comp_tb_top.sv
`timescale 1ns/1ps
module cic_droop_comp_tb_top;

    localparam int IN_W  = 8;
    localparam int OUT_W = IN_W + 11;
    localparam int NSTIM = 24;

    // Stimulus vectors: bit 8 = strobe, bits 7:0 = two's-complement sample
    localparam logic [8:0] STIM [NSTIM] = '{
        9'h101, 9'h100, 9'h100, 9'h100, 9'h100, 9'h100,
        9'h0AA, 9'h055,
        9'h17F, 9'h180, 9'h17F, 9'h180, 9'h17F,
        9'h0FF, 9'h10A, 9'h1F6, 9'h000, 9'h133, 9'h1C0, 9'h081,
        9'h105, 9'h1FB, 9'h100, 9'h100
    };

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    valid_in = 1'b0;
    logic signed [IN_W-1:0]  sample_in = '0;
    logic                    valid_out;
    logic signed [OUT_W-1:0] result_out;
    logic                    vv [1:6];
    logic signed [OUT_W-1:0] yv [1:6];

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    // Bench model state
    int hist [5];
    int pv0, pv1;
    int py0 [1:6];
    int py1 [1:6];
    int hold [1:6];

    always #10 clk = ~clk;

    cic_droop_comp #(.STAGES(4), .IN_W(IN_W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .valid_in   (valid_in),
        .sample_in  (sample_in),
        .valid_out  (valid_out),
        .result_out (result_out)
    );

    for (genvar g = 1; g <= 6; g++) begin : g_alt
        cic_droop_comp #(.STAGES(g), .IN_W(IN_W)) dut_n (
            .clk        (clk),
            .rst        (rst),
            .valid_in   (valid_in),
            .sample_in  (sample_in),
            .valid_out  (vv[g]),
            .result_out (yv[g])
        );
    end

    function automatic int bcoef(int n, int k);
        int c0, c1, c2;
        case (n)
            1: begin c0 = 2;  c1 = -18;  c2 = 288; end
            2: begin c0 = 5;  c1 = -40;  c2 = 326; end
            3: begin c0 = 9;  c1 = -65;  c2 = 368; end
            4: begin c0 = 14; c1 = -94;  c2 = 416; end
            5: begin c0 = 21; c1 = -129; c2 = 472; end
            default: begin c0 = 29; c1 = -168; c2 = 534; end
        endcase
        if (k == 0 || k == 4) return c0;
        if (k == 1 || k == 3) return c1;
        return c2;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < 5; k++) hist[k] = 0;
        pv0 = 0;
        pv1 = 0;
        for (int n = 1; n <= 6; n++) begin
            py0[n] = 0; py1[n] = 0; hold[n] = 0;
        end
    endtask

    // One cycle: compare outputs with the model, then drive the next input
    task automatic step(input logic v, input logic [7:0] x);
        @(negedge clk);
        check("R1 valid_out latency", longint'(valid_out), longint'(pv1));
        for (int n = 1; n <= 6; n++) begin
            if (pv1 != 0) hold[n] = py1[n];
            check($sformatf("R3 stages=%0d result", n), longint'(yv[n]), longint'(hold[n]));
        end
        check("R2 result N=4", longint'(result_out), longint'(hold[4]));
        pv1 = pv0;
        for (int n = 1; n <= 6; n++) py1[n] = py0[n];
        if (v) begin
            for (int k = 4; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = int'($signed(x));
        end
        pv0 = v ? 1 : 0;
        for (int n = 1; n <= 6; n++) begin
            int acc;
            acc = 0;
            for (int k = 0; k < 5; k++) acc += bcoef(n, k) * hist[k];
            py0[n] = v ? acc : 0;
        end
        valid_in  = v;
        sample_in = x;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        valid_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        // R7: outputs cleared while reset is held
        check("R7 valid_out in reset", longint'(valid_out), 0);
        check("R7 result_out in reset", longint'(result_out), 0);
        for (int n = 1; n <= 6; n++)
            check("R7 result_out in reset (all stages)", longint'(yv[n]), 0);
        rst = 1'b0;
        model_clear();
    endtask

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        check("R7 valid_out after power-up reset", longint'(valid_out), 0);
        check("R7 result_out after power-up reset", longint'(result_out), 0);
        rst = 1'b0;

        // Vector table: impulse, ignored gaps, extremes, mixed values (R2, R3, R5)
        for (int i = 0; i < NSTIM; i++) step(STIM[i][8], STIM[i][7:0]);
        step(1'b0, 8'h00);
        step(1'b0, 8'h00);

        // R7: mid-stream reset clears history; next impulse shows g0 alone
        step(1'b1, 8'h40);
        apply_reset();
        step(1'b1, 8'h01);
        step(1'b0, 8'h00);
        step(1'b0, 8'h00);
        check("R7 no stale history after reset", longint'(result_out), 14);

        // R4: DC gain of 256 for a held negative extreme
        apply_reset();
        for (int i = 0; i < 6; i++) step(1'b1, 8'h80);
        step(1'b0, 8'h00);
        step(1'b0, 8'h00);
        for (int n = 1; n <= 6; n++)
            check($sformatf("R4 DC gain stages=%0d, -128", n), longint'(yv[n]), -32768);

        // R4: DC gain for a positive value
        apply_reset();
        for (int i = 0; i < 5; i++) step(1'b1, 8'h7F);
        step(1'b0, 8'h00);
        step(1'b0, 8'h00);
        for (int n = 1; n <= 6; n++)
            check($sformatf("R4 DC gain stages=%0d, 127", n), longint'(yv[n]), 32512);

        // R6: worst-case alternating extremes, beyond 17-bit range
        apply_reset();
        step(1'b1, 8'h7F);
        step(1'b1, 8'h80);
        step(1'b1, 8'h7F);
        step(1'b1, 8'h80);
        step(1'b1, 8'h7F);
        step(1'b0, 8'h00);
        step(1'b0, 8'h00);
        check("R6 full precision stages=4", longint'(result_out), 80452);
        check("R6 full precision stages=6", longint'(yv[6]), 118192);

        // R5: idle cycles with changing data leave output and history intact
        step(1'b0, 8'h55);
        step(1'b0, 8'hAA);
        step(1'b0, 8'h33);
        check("R5 output held while idle", longint'(result_out), 80452);
        check("R5 valid_out low while idle", longint'(valid_out), 0);
        step(1'b1, 8'h00);
        step(1'b0, 8'h00);
        step(1'b0, 8'h00);
        // history shifted once: newest 0, then 127,-128,127,-128
        check("R5 history untouched by idle cycles", longint'(result_out),
              longint'(-94*127 + 416*(-128) - 94*127 + 14*(-128)));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule